// File: doc/BRIEF.md
# Variable refresh vertical timing generator

This block produces the vertical timing of one display pipe. A line counter advances on each scanline tick and runs through active video into vertical blank. With variable refresh off, every frame has the fixed total `cfg_vtotal`. With it on, vertical blank stays open. It exits early when software sends a push, no earlier than the flip line. If no push comes, exit is forced at a decision line derived from the maximum line count and a guardband. A frame-start strobe follows the exit after a programmable delay of 1 to 4 lines.

Software programs the block through a small register port. The min, max and flip-line registers are shadowed. The shadow values are copied into the working copy on a single latch strobe. That strobe fires at vertical blank start in fixed mode and at the start of vertical blank exit in variable mode. A live status bit shows whether variable refresh is in force for the current frame.

Top module: `vrr_vtiming`

## Requirements
- R1: When the live bit is clear, every frame is exactly `cfg_vtotal` lines long. The shadow registers are latched when the counter reaches `cfg_vactive`, the first blank line.
- R2: The register map is: address 0 min, 1 max, 2 flip line, 3 control, 4 push, 5 status, 6 current line. Addresses 0 to 2 store the line count minus one, and a read of them returns the stored value plus one.
- R3: The push register has enable in bit 0 and send in bit 1. A write sets send only if bit 0 is also written as 1. Send reads back as 1 until the push is consumed.
- R4: In variable mode, a push sent during active video or before the flip line is held. With flip-line enable on, exit begins on the first line that is in blank and has a line number of at least flip count (flip register plus one).
- R5: With flip-line enable off, a pending push starts the exit on the first blank line.
- R6: Without a push, exit is forced on line (max register + 1 − guardband).
- R7: The control register holds enable in bit 0, flip-line enable in bit 1, a stored-only hold flag in bit 2, frame-start delay minus one in bits 4:3, and guardband in bits 15:8. The counter wraps to 0 and `frame_start` pulses after the number of delay lines that follow the exit line, so a frame is exit line + delay lines long.
- R8: The start of a variable-mode exit pulses `latch_stb`, copies the shadow registers into the working copy, and clears send.
- R9: After software clears the enable bit, `vrr_live` stays 1 until the next latch. The frame that is running finishes under variable-mode rules.
- R10: After reset the line counter, live bit and strobes are 0. Address 6 reads the current line, which is 0 just after each frame start. `vblank` is 1 while the line is at least `cfg_vactive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per scanline |
| cfg_vactive | input | W | Active lines per frame |
| cfg_vtotal | input | W | Fixed frame total |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Read data, combinational |
| vblank | output | 1 | Vertical blank |
| latch_stb | output | 1 | Shadow-to-working latch pulse |
| frame_start | output | 1 | Frame start pulse |
| vrr_live | output | 1 | Variable refresh in force |

## Verification
The assertions check on every cycle that latch and frame-start pulses never coincide. They also check that a latch only happens in blank and a frame start only outside it, that send only clears through a latch or a write, and that the live bit falls only at a latch. Frame lengths under push, flip-line, forced-exit and delay settings can only be shown by the bench's frames. The same holds for readback encoding and for the one-frame lag after enable is cleared.

// File: rtl/vrr_vtiming.sv
module vrr_vtiming #(
  parameter int W  = 16,
  parameter int GW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_tick,
  input  logic [W-1:0] cfg_vactive,
  input  logic [W-1:0] cfg_vtotal,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         vblank,
  output logic         latch_stb,
  output logic         frame_start,
  output logic         vrr_live
);
  localparam int GB_LSB = 8;

  logic [W-1:0]  line_q, min_q, max_q, flip_q, ctrl_q, max_a, flip_a;
  logic          push_en_q, send_q, live_q, flip_en_q, exit_q;
  logic [1:0]    dly_q, exit_cnt_q;
  logic [GW-1:0] guard_q;

  wire [W-1:0] nl          = line_q + 1'b1;
  wire [W-1:0] forced_line = max_a + 1'b1 - W'(guard_q);
  wire         flip_ok     = !flip_en_q || (nl >= flip_a + 1'b1);
  wire         push_wr     = wr_en && (wr_addr == 3'd4);
  wire         go_exit     = line_tick && live_q && !exit_q && (nl >= cfg_vactive) &&
                             ((push_en_q && send_q && flip_ok) || (nl >= forced_line));
  wire         fix_wrap    = line_tick && !live_q && !exit_q && (nl >= cfg_vtotal);
  wire         fix_latch   = line_tick && !live_q && !exit_q && (nl == cfg_vactive);
  wire         exit_done   = line_tick && exit_q && (exit_cnt_q == 2'd0);
  wire         do_latch    = go_exit || fix_latch;

  assign vblank   = line_q >= cfg_vactive;
  assign vrr_live = live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q      <= '0;
      exit_q      <= 1'b0;
      exit_cnt_q  <= '0;
      latch_stb   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      latch_stb   <= do_latch;
      frame_start <= exit_done || fix_wrap;
      if (line_tick) line_q <= (exit_done || fix_wrap) ? '0 : nl;
      if (go_exit) begin
        exit_q     <= 1'b1;
        exit_cnt_q <= dly_q;
      end else if (line_tick && exit_q) begin
        if (exit_cnt_q == 2'd0) exit_q <= 1'b0;
        else exit_cnt_q <= exit_cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0; max_q <= '0; flip_q <= '0; ctrl_q <= '0;
      push_en_q <= 1'b0; send_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: min_q  <= wr_data;
          3'd1: max_q  <= wr_data;
          3'd2: flip_q <= wr_data;
          3'd3: ctrl_q <= wr_data;
          default: ;
        endcase
      end
      if (push_wr) begin
        push_en_q <= wr_data[0];
        send_q    <= wr_data[0] & wr_data[1];
      end else if (go_exit) begin
        send_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_a <= '0; flip_a <= '0; live_q <= 1'b0; flip_en_q <= 1'b0;
      dly_q <= '0; guard_q <= '0;
    end else if (do_latch) begin
      max_a     <= max_q;
      flip_a    <= flip_q;
      live_q    <= ctrl_q[0];
      flip_en_q <= ctrl_q[1];
      dly_q     <= ctrl_q[4:3];
      guard_q   <= ctrl_q[GB_LSB +: GW];
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = min_q + 1'b1;
      3'd1:    rd_data = max_q + 1'b1;
      3'd2:    rd_data = flip_q + 1'b1;
      3'd3:    rd_data = ctrl_q;
      3'd4:    rd_data = W'({send_q, push_en_q});
      3'd5:    rd_data = W'(live_q);
      3'd6:    rd_data = line_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/vrr_vtiming_chk.sv
module vrr_vtiming_chk (
  input logic clk,
  input logic rst_n,
  input logic vblank,
  input logic latch_stb,
  input logic frame_start,
  input logic live,
  input logic send,
  input logic push_wr
);
  // R8
  latch_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> vblank);
  // R10
  start_outside_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !vblank);
  // R7
  strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({latch_stb, frame_start}));
  // R8
  send_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !push_wr) |=> (send || latch_stb));
  // R9
  live_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live) |-> latch_stb);
endmodule

bind vrr_vtiming vrr_vtiming_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .latch_stb(latch_stb),
  .frame_start(frame_start), .live(vrr_live), .send(send_q), .push_wr(push_wr)
);

// File: tb/vrr_vtiming_tb_top.sv
module vrr_vtiming_tb_top;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, line_tick = 0, wr_en = 0;
  logic [W-1:0] cfg_vactive = 16'd10, cfg_vtotal = 16'd20, wr_data = '0, rd_data;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic vblank, latch_stb, frame_start, vrr_live;
  int checks = 0, fails = 0, tick_cnt = 0, frame_no = 0;
  int exp_q[$];
  bit done = 0;
  event fs_ev;

  always #4 clk = ~clk;

  vrr_vtiming dut_i (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    @(negedge clk); rd_addr = 3'(a); #1;
    check(req, int'(rd_data), exp);
  endtask

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      line_tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  // monitor: frame length scoreboard
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        if (line_tick) tick_cnt++;
        if (frame_start) begin
          frame_no++;
          if (exp_q.size() == 0) check("R1 unexpected frame", tick_cnt, -1);
          else check($sformatf("R1/R4/R5/R6/R7 frame %0d length", frame_no), tick_cnt, exp_q.pop_front());
          tick_cnt = 0;
          -> fs_ev;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    rd_chk("R10 reset line", 6, 0);
    check("R10 reset vblank", vblank, 0);
    check("R10 reset live", vrr_live, 0);
    check("R10 reset strobes", {latch_stb, frame_start}, 0);
    @(negedge clk); rst_n = 1;
    exp_q.push_back(20);                       // R1 fixed frame
    @(fs_ev);
    rd_chk("R10 line zero at frame start", 6, 0);
    exp_q.push_back(36);                       // R6 forced exit 34, R7 delay 2
    wr(0, 21); wr(1, 39); wr(2, 24); wr(3, 16'h060B);
    rd_chk("R2 min readback", 0, 22);
    rd_chk("R7 control readback", 3, 16'h060B);
    @(fs_ev);
    exp_q.push_back(27);                       // R4 push held to flip line 25
    wr(4, 3);
    rd_chk("R3 send pending", 4, 3);
    rd_chk("R2 max readback", 1, 40);
    @(fs_ev);
    rd_chk("R8 send consumed", 4, 1);
    exp_q.push_back(36);
    wr(3, 16'h0609);
    @(fs_ev);
    exp_q.push_back(12);                       // R5 flip off, exit at first blank line
    wr(4, 3);
    @(fs_ev);
    exp_q.push_back(36);                       // R9 frame still variable
    wr(3, 0);
    repeat (20) @(negedge clk);
    check("R9 live held after clearing enable", vrr_live, 1);
    @(fs_ev);
    rd_chk("R9 live cleared at latch", 5, 0);
    exp_q.push_back(20);                       // R1 fixed again, push no effect
    wr(4, 2);
    rd_chk("R3 send needs enable", 4, 0);
    wr(4, 3);
    @(fs_ev);
    exp_q.push_back(20);
    @(fs_ev);
    done = 1;
    check("R1 queue drained", exp_q.size(), 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule